// File: doc/BRIEF.md
# Hot-plug slot command controller

This block is the command engine of a hot-plug controller for a bridge with up to 31 removable slots. Software writes an eight-bit command code together with a five-bit target. The block checks each request against the state already held for the slot before applying it. It keeps three fields for every slot: the slot state, the power indicator and the attention indicator. It also keeps a latch-open flag, a presence code and three sticky event bits per slot.

A single-slot command can change the indicators, move a slot between its states, or take a slot out. A slot is taken out when it is disabled while its power indicator is off. The block then reports the slot as emptied and pulses a per-slot removal output for one cycle, which tells the surrounding logic to detach the device. Two broadcast commands power all slots or enable all slots, and a third group of codes selects the secondary bus speed.

Every command completes one clock edge after its strobe. At that edge the block rewrites a four-bit command status and raises a sticky command-detected flag. Interrupt generation and the register bus sit outside the block.

Top module: `hpc_slot_ctrl`

## Requirements
- R1: While reset is held, a slot whose occupied input is high is set to enabled (state 2), with power indicator on (1), latch closed and presence code 0. Every other slot is set to disabled (3), with power indicator off (3), latch open and presence code 3. In both cases the attention indicator is 0 and the events are 0. Status is 0, detected is 0 and bus speed is 0.
- R2: A code below 0x40 is a single-slot command, with the requested state in bits [1:0], the power indicator in bits [3:2] and the attention indicator in bits [5:4]. An indicator field of 0 keeps the current value, and 1, 2 or 3 (on, blink, off) replaces it.
- R3: When a single-slot command names target 0 or a target above the slot count, status bit 2 (invalid command) is set and no slot changes.
- R4: A request for state 1 (power only) to an enabled slot sets status bit 2 and changes nothing, indicators included. A disabled slot moves to state 1 or 2 on request. A slot in state 1 or 2 moves to disabled on request. Every other pairing leaves the state as it is, and no slot changes without a command.
- R5: When a slot enters disabled and its power indicator (after the indicator update of the same command) reads off, the slot shows the latch open and presence 3. Its event bits (bit0 presence, bit1 button, bit2 latch) are all set, and its removal output is high for exactly the following cycle.
- R6: Codes 0x40 to 0x47 select the bus speed from bits [2:0]. A speed of 0 is accepted, and any other value sets status bit 3 (invalid mode) and leaves the speed at 0.
- R7: Code 0x48 (power all) and code 0x49 (enable all) set status bit 2 and change no slot if any slot is enabled.
- R8: When not refused, codes 0x48 and 0x49 handle each slot by its latch. A slot with its latch closed receives a request for state 1 or 2 respectively with the power indicator on. A slot with its latch open receives only a power indicator of off. Both requests follow the rules of R4.
- R9: Codes above 0x49 set status bit 2. Every command first clears all four status bits. Bit 0 (busy) and bit 1 are never set.
- R10: The detected flag is high from the cycle after any command, failed ones included. An acknowledge clears it, unless a command arrives in the same cycle.
- R11: Event bits stay set until the slot's event-clear input is pulsed. A removal in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_occ_i | input | NSLOT | Slot occupied at reset, one bit per slot |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_code_i | input | 8 | Command code |
| cmd_target_i | input | 5 | Target slot number, 1-based |
| cmd_ack_i | input | 1 | Clears the detected flag |
| evt_clr_i | input | NSLOT | Per-slot event clear |
| slot_state_o | output | 2*NSLOT | Slot state per slot |
| pwr_led_o | output | 2*NSLOT | Power indicator per slot |
| attn_led_o | output | 2*NSLOT | Attention indicator per slot |
| latch_open_o | output | NSLOT | Latch open per slot |
| presence_o | output | 2*NSLOT | Presence code per slot |
| slot_evt_o | output | 3*NSLOT | Sticky events per slot |
| removal_o | output | NSLOT | One-cycle removal request per slot |
| cmd_status_o | output | 4 | Command status bits |
| cmd_detected_o | output | 1 | Sticky command-detected flag |
| bus_speed_o | output | 3 | Selected secondary bus speed |

## Verification
The block is driven first with a fixed sequence and then with a long pseudo-random stream, against a behavioural model compared on every clock. The fixed sequence separates four families of input. Out-of-range targets (0 and one above the count) show that validation happens before any effect. Forbidden transitions, carrying non-zero indicator fields, show that a refusal also discards the indicators. Disable requests with the power indicator left on or driven off separate a plain disable from a removal. Broadcast commands are tried with one slot still enabled and then after all slots are cleared, and one slot in power-only proves that the enable-all request honours the transition table and not a forced state. The random stream mixes acknowledges and event clears into the same cycles as commands, which tests the set-wins ordering.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int TGT_W = 5;
    localparam int CODE_W = 8;
    localparam int STAT_W = 4;
    localparam int EVT_W = 3;

    // Slot state encoding (register field).
    localparam logic [1:0] ST_KEEP = 2'd0;
    localparam logic [1:0] ST_PWR  = 2'd1;
    localparam logic [1:0] ST_EN   = 2'd2;
    localparam logic [1:0] ST_DIS  = 2'd3;

    // Indicator encoding.
    localparam logic [1:0] LED_KEEP  = 2'd0;
    localparam logic [1:0] LED_ON    = 2'd1;
    localparam logic [1:0] LED_BLINK = 2'd2;
    localparam logic [1:0] LED_OFF   = 2'd3;

    localparam logic [1:0] PRES_EMPTY = 2'd3;
    localparam logic [1:0] PRES_LOW   = 2'd0;

    // Status bit positions.
    localparam int SB_BUSY    = 0;
    localparam int SB_LATCH   = 1;
    localparam int SB_BADCMD  = 2;
    localparam int SB_BADMODE = 3;

    // Event bit positions.
    localparam int EV_PRES  = 0;
    localparam int EV_BTN   = 1;
    localparam int EV_LATCH = 2;

    localparam logic [CODE_W-1:0] CODE_PWR_ALL = 8'h48;
    localparam logic [CODE_W-1:0] CODE_EN_ALL  = 8'h49;

    typedef enum logic [2:0] {
        K_SLOT,
        K_SPEED,
        K_PWR_ALL,
        K_EN_ALL,
        K_BAD
    } cmd_kind_e;

    typedef struct packed {
        logic [1:0]       state;
        logic [1:0]       pwr;
        logic [1:0]       attn;
        logic             latch_open;
        logic [1:0]       presence;
        logic [EVT_W-1:0] evt;
    } slot_t;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output cmd_kind_e         kind_o,
    output logic [1:0]        req_state_o,
    output logic [1:0]        req_pwr_o,
    output logic [1:0]        req_attn_o,
    output logic [2:0]        speed_o
);

    always_comb begin
        req_state_o = code_i[1:0];
        req_pwr_o   = code_i[3:2];
        req_attn_o  = code_i[5:4];
        speed_o     = code_i[2:0];
        if (code_i[7:6] == 2'b00) begin
            kind_o = K_SLOT;
        end else if (code_i[7:3] == 5'b01000) begin
            kind_o = K_SPEED;
        end else if (code_i == CODE_PWR_ALL) begin
            kind_o = K_PWR_ALL;
        end else if (code_i == CODE_EN_ALL) begin
            kind_o = K_EN_ALL;
        end else begin
            kind_o = K_BAD;
        end
    end

endmodule

// File: rtl/hpc_slot_step.sv
module hpc_slot_step
    import hpc_pkg::*;
(
    input  slot_t      cur_i,
    input  logic       apply_i,
    input  logic [1:0] req_state_i,
    input  logic [1:0] req_pwr_i,
    input  logic [1:0] req_attn_i,
    output slot_t      nxt_o,
    output logic       reject_o,
    output logic       removed_o
);

    always_comb begin
        reject_o  = (cur_i.state == ST_EN) && (req_state_i == ST_PWR);
        nxt_o     = cur_i;
        removed_o = 1'b0;
        if (apply_i && !reject_o) begin
            if (req_pwr_i != LED_KEEP) begin
                nxt_o.pwr = req_pwr_i;
            end
            if (req_attn_i != LED_KEEP) begin
                nxt_o.attn = req_attn_i;
            end
            if ((cur_i.state == ST_DIS) &&
                ((req_state_i == ST_PWR) || (req_state_i == ST_EN))) begin
                nxt_o.state = req_state_i;
            end else if (((cur_i.state == ST_EN) || (cur_i.state == ST_PWR)) &&
                         (req_state_i == ST_DIS)) begin
                nxt_o.state = ST_DIS;
                if (nxt_o.pwr == LED_OFF) begin
                    nxt_o.latch_open = 1'b1;
                    nxt_o.presence   = PRES_EMPTY;
                    nxt_o.evt[EV_PRES]  = 1'b1;
                    nxt_o.evt[EV_BTN]   = 1'b1;
                    nxt_o.evt[EV_LATCH] = 1'b1;
                    removed_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hpc_slot_ctrl.sv
module hpc_slot_ctrl
    import hpc_pkg::*;
#(
    parameter int NSLOT = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSLOT-1:0]      slot_occ_i,
    input  logic                  cmd_valid_i,
    input  logic [7:0]            cmd_code_i,
    input  logic [4:0]            cmd_target_i,
    input  logic                  cmd_ack_i,
    input  logic [NSLOT-1:0]      evt_clr_i,
    output logic [2*NSLOT-1:0]    slot_state_o,
    output logic [2*NSLOT-1:0]    pwr_led_o,
    output logic [2*NSLOT-1:0]    attn_led_o,
    output logic [NSLOT-1:0]      latch_open_o,
    output logic [2*NSLOT-1:0]    presence_o,
    output logic [3*NSLOT-1:0]    slot_evt_o,
    output logic [NSLOT-1:0]      removal_o,
    output logic [3:0]            cmd_status_o,
    output logic                  cmd_detected_o,
    output logic [2:0]            bus_speed_o
);

    localparam int MAX_TGT = (1 << TGT_W) - 1;

    typedef struct packed {
        slot_t [NSLOT-1:0] slots;
        logic [NSLOT-1:0]  removal;
        logic [STAT_W-1:0] status;
        logic              detected;
        logic [2:0]        speed;
    } ctl_t;

    ctl_t ctl_d, ctl_q, ctl_rst;

    cmd_kind_e  dec_kind;
    logic [1:0] dec_state, dec_pwr, dec_attn;
    logic [2:0] dec_speed;

    hpc_cmd_decode u_dec (
        .code_i      (cmd_code_i),
        .kind_o      (dec_kind),
        .req_state_o (dec_state),
        .req_pwr_o   (dec_pwr),
        .req_attn_o  (dec_attn),
        .speed_o     (dec_speed)
    );

    logic             all_cmd;
    logic             tgt_ok;
    logic [NSLOT-1:0] slot_en;
    logic             any_en;
    logic [NSLOT-1:0] tgt_hit, apply, reject, reject_hit, removed;
    slot_t            step_nxt [NSLOT];

    assign all_cmd = (dec_kind == K_PWR_ALL) || (dec_kind == K_EN_ALL);
    assign tgt_ok  = (cmd_target_i != '0) && (int'(cmd_target_i) <= NSLOT);
    assign any_en  = |slot_en;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [1:0] rq_state, rq_pwr, rq_attn;

        assign slot_en[i] = (ctl_q.slots[i].state == ST_EN);
        assign tgt_hit[i] = (dec_kind == K_SLOT) &&
                            (cmd_target_i == TGT_W'(i + 1));

        always_comb begin
            if (all_cmd) begin
                rq_attn = LED_KEEP;
                if (ctl_q.slots[i].latch_open) begin
                    rq_state = ST_KEEP;
                    rq_pwr   = LED_OFF;
                end else begin
                    rq_state = (dec_kind == K_PWR_ALL) ? ST_PWR : ST_EN;
                    rq_pwr   = LED_ON;
                end
            end else begin
                rq_state = dec_state;
                rq_pwr   = dec_pwr;
                rq_attn  = dec_attn;
            end
        end

        assign apply[i] = cmd_valid_i && (tgt_hit[i] || (all_cmd && !any_en));
        assign reject_hit[i] = tgt_hit[i] && reject[i];

        hpc_slot_step u_step (
            .cur_i       (ctl_q.slots[i]),
            .apply_i     (apply[i]),
            .req_state_i (rq_state),
            .req_pwr_i   (rq_pwr),
            .req_attn_i  (rq_attn),
            .nxt_o       (step_nxt[i]),
            .reject_o    (reject[i]),
            .removed_o   (removed[i])
        );

        assign slot_state_o[2*i +: 2] = ctl_q.slots[i].state;
        assign pwr_led_o[2*i +: 2]    = ctl_q.slots[i].pwr;
        assign attn_led_o[2*i +: 2]   = ctl_q.slots[i].attn;
        assign latch_open_o[i]        = ctl_q.slots[i].latch_open;
        assign presence_o[2*i +: 2]   = ctl_q.slots[i].presence;
        assign slot_evt_o[3*i +: 3]   = ctl_q.slots[i].evt;
        assign removal_o[i]           = ctl_q.removal[i];

        AST_REMOVAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
            removal_o[i] |-> (slot_state_o[2*i +: 2] == ST_DIS) &&
                             latch_open_o[i] &&
                             (presence_o[2*i +: 2] == PRES_EMPTY) &&
                             (slot_evt_o[3*i +: 3] == 3'b111)); // R5
    end

    // Reset image, built from the occupancy inputs.
    always_comb begin
        ctl_rst = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_occ_i[i]) begin
                ctl_rst.slots[i].state      = ST_EN;
                ctl_rst.slots[i].pwr        = LED_ON;
                ctl_rst.slots[i].latch_open = 1'b0;
                ctl_rst.slots[i].presence   = PRES_LOW;
            end else begin
                ctl_rst.slots[i].state      = ST_DIS;
                ctl_rst.slots[i].pwr        = LED_OFF;
                ctl_rst.slots[i].latch_open = 1'b1;
                ctl_rst.slots[i].presence   = PRES_EMPTY;
            end
        end
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.removal = '0;
        if (cmd_ack_i) begin
            ctl_d.detected = 1'b0;
        end
        for (int i = 0; i < NSLOT; i++) begin
            ctl_d.slots[i]   = step_nxt[i];
            ctl_d.removal[i] = removed[i];
            if (evt_clr_i[i] && !removed[i]) begin
                ctl_d.slots[i].evt = '0;
            end
        end
        if (cmd_valid_i) begin
            ctl_d.status   = '0;
            ctl_d.detected = 1'b1;
            unique case (dec_kind)
                K_SLOT: begin
                    if (!tgt_ok || (|reject_hit)) begin
                        ctl_d.status[SB_BADCMD] = 1'b1;
                    end
                end
                K_SPEED: begin
                    if (dec_speed == 3'd0) begin
                        ctl_d.speed = dec_speed;
                    end else begin
                        ctl_d.status[SB_BADMODE] = 1'b1;
                    end
                end
                K_PWR_ALL, K_EN_ALL: begin
                    if (any_en) begin
                        ctl_d.status[SB_BADCMD] = 1'b1;
                    end
                end
                default: begin
                    ctl_d.status[SB_BADCMD] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= ctl_rst;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_status_o   = ctl_q.status;
    assign cmd_detected_o = ctl_q.detected;
    assign bus_speed_o    = ctl_q.speed;

    AST_DETECT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> cmd_detected_o); // R10

    AST_TARGET_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_code_i < 8'h40) && (cmd_target_i == '0))
        |=> cmd_status_o[SB_BADCMD] && $stable(slot_state_o) && $stable(pwr_led_o)); // R3

    AST_ALL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && all_cmd && any_en)
        |=> cmd_status_o[SB_BADCMD] && $stable(slot_state_o) && $stable(pwr_led_o)); // R7

    AST_SPEED_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_code_i[7:3] == 5'b01000) && (cmd_code_i[2:0] != 3'd0))
        |=> cmd_status_o[SB_BADMODE] && (bus_speed_o == 3'd0)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> $stable(slot_state_o) && $stable(pwr_led_o) &&
                         $stable(attn_led_o) && (removal_o == '0)); // R4

    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> (cmd_status_o[SB_BUSY] == 1'b0) &&
                        (cmd_status_o[SB_LATCH] == 1'b0)); // R9

    initial begin
        assert (MAX_TGT >= NSLOT && NSLOT >= 1); // R3
    end

endmodule

// File: tb/hpc_slot_ctrl_bench.sv
module hpc_slot_ctrl_bench;

    localparam int NS = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   slot_occ = 6'b001011;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_code = '0;
    logic [4:0]      cmd_target = '0;
    logic            cmd_ack = 1'b0;
    logic [NS-1:0]   evt_clr = '0;
    logic [2*NS-1:0] slot_state, pwr_led, attn_led, presence;
    logic [NS-1:0]   latch_open, removal;
    logic [3*NS-1:0] slot_evt;
    logic [3:0]      cmd_status;
    logic            cmd_detected;
    logic [2:0]      bus_speed;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hpc_slot_ctrl #(.NSLOT(NS)) u_hpc_slot_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_occ_i     (slot_occ),
        .cmd_valid_i    (cmd_valid),
        .cmd_code_i     (cmd_code),
        .cmd_target_i   (cmd_target),
        .cmd_ack_i      (cmd_ack),
        .evt_clr_i      (evt_clr),
        .slot_state_o   (slot_state),
        .pwr_led_o      (pwr_led),
        .attn_led_o     (attn_led),
        .latch_open_o   (latch_open),
        .presence_o     (presence),
        .slot_evt_o     (slot_evt),
        .removal_o      (removal),
        .cmd_status_o   (cmd_status),
        .cmd_detected_o (cmd_detected),
        .bus_speed_o    (bus_speed)
    );

    // Behavioural reference model.
    int m_st[NS], m_pw[NS], m_at[NS], m_lo[NS], m_pr[NS], m_ev[NS], m_rm[NS];
    int m_status = 0, m_det = 0, m_spd = 0;

    task automatic model_apply(input int s, input int rs, input int rp, input int ra,
                               output bit bad);
        bad = 0;
        if (m_st[s] == 2 && rs == 1) begin
            bad = 1;
            return;
        end
        if (rp != 0) m_pw[s] = rp;
        if (ra != 0) m_at[s] = ra;
        if (m_st[s] == 3 && (rs == 1 || rs == 2)) begin
            m_st[s] = rs;
        end else if ((m_st[s] == 1 || m_st[s] == 2) && rs == 3) begin
            m_st[s] = 3;
            if (m_pw[s] == 3) begin
                m_lo[s] = 1;
                m_pr[s] = 3;
                m_ev[s] = 7;
                m_rm[s] = 1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_st[i] = slot_occ[i] ? 2 : 3;
                m_pw[i] = slot_occ[i] ? 1 : 3;
                m_lo[i] = slot_occ[i] ? 0 : 1;
                m_pr[i] = slot_occ[i] ? 0 : 3;
                m_at[i] = 0;
                m_ev[i] = 0;
                m_rm[i] = 0;
            end
            m_status = 0;
            m_det = 0;
            m_spd = 0;
        end else begin
            int code;
            int tgt;
            bit bad;
            bit enabled_seen;
            code = int'(cmd_code);
            tgt = int'(cmd_target);
            for (int i = 0; i < NS; i++) m_rm[i] = 0;
            if (cmd_ack) m_det = 0;
            if (cmd_valid) begin
                m_status = 0;
                m_det = 1;
                if (code < 'h40) begin
                    if (tgt == 0 || tgt > NS) begin
                        m_status = 4;
                    end else begin
                        model_apply(tgt - 1, code % 4, (code / 4) % 4, (code / 16) % 4, bad);
                        if (bad) m_status = 4;
                    end
                end else if (code < 'h48) begin
                    if (code % 8 != 0) m_status = 8;
                    else m_spd = 0;
                end else if (code == 'h48 || code == 'h49) begin
                    enabled_seen = 0;
                    for (int i = 0; i < NS; i++) if (m_st[i] == 2) enabled_seen = 1;
                    if (enabled_seen) begin
                        m_status = 4;
                    end else begin
                        for (int i = 0; i < NS; i++) begin
                            if (m_lo[i] == 0)
                                model_apply(i, (code == 'h48) ? 1 : 2, 1, 0, bad);
                            else
                                model_apply(i, 0, 3, 0, bad);
                        end
                    end
                end else begin
                    m_status = 4;
                end
            end
            for (int i = 0; i < NS; i++) begin
                if (evt_clr[i] && m_rm[i] == 0) m_ev[i] = 0;
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int f_st(input int s);  return int'(slot_state[2*s +: 2]); endfunction
    function automatic int f_pw(input int s);  return int'(pwr_led[2*s +: 2]);    endfunction
    function automatic int f_at(input int s);  return int'(attn_led[2*s +: 2]);   endfunction
    function automatic int f_pr(input int s);  return int'(presence[2*s +: 2]);   endfunction
    function automatic int f_ev(input int s);  return int'(slot_evt[3*s +: 3]);   endfunction

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            for (int i = 0; i < NS; i++) begin
                check_eq($sformatf("R4 model state slot%0d", i), f_st(i), m_st[i]);
                check_eq($sformatf("R2 model pwr slot%0d", i), f_pw(i), m_pw[i]);
                check_eq($sformatf("R2 model attn slot%0d", i), f_at(i), m_at[i]);
                check_eq($sformatf("R5 model latch slot%0d", i), int'(latch_open[i]), m_lo[i]);
                check_eq($sformatf("R5 model presence slot%0d", i), f_pr(i), m_pr[i]);
                check_eq($sformatf("R11 model events slot%0d", i), f_ev(i), m_ev[i]);
                check_eq($sformatf("R5 model removal slot%0d", i), int'(removal[i]), m_rm[i]);
            end
            check_eq("R9 model status", int'(cmd_status), m_status);
            check_eq("R10 model detected", int'(cmd_detected), m_det);
            check_eq("R6 model speed", int'(bus_speed), m_spd);
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            report();
        end
    end

    // Called at a falling edge; returns at the next falling edge with results visible.
    task automatic issue(input int code, input int tgt);
        cmd_code = 8'(code);
        cmd_target = 5'(tgt);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack();
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        check_eq("R1 slot0 state", f_st(0), 2);
        check_eq("R1 slot0 pwr", f_pw(0), 1);
        check_eq("R1 slot0 latch", int'(latch_open[0]), 0);
        check_eq("R1 slot2 state", f_st(2), 3);
        check_eq("R1 slot2 pwr", f_pw(2), 3);
        check_eq("R1 slot2 presence", f_pr(2), 3);
        check_eq("R1 status", int'(cmd_status), 0);
        check_eq("R1 detected", int'(cmd_detected), 0);

        issue('h49, 0);
        check_eq("R7 enable-all refused status", int'(cmd_status), 4);
        check_eq("R7 slot2 unchanged", f_st(2), 3);
        check_eq("R10 detected set on failure", int'(cmd_detected), 1);
        ack();
        check_eq("R10 ack clears", int'(cmd_detected), 0);

        issue('h07, 0);
        check_eq("R3 target zero", int'(cmd_status), 4);
        check_eq("R3 slot0 pwr kept", f_pw(0), 1);
        issue('h07, 7);
        check_eq("R3 target beyond count", int'(cmd_status), 4);
        check_eq("R3 slot0 state kept", f_st(0), 2);

        issue('h3D, 1);
        check_eq("R4 power-only from enabled refused", int'(cmd_status), 4);
        check_eq("R4 refused keeps pwr", f_pw(0), 1);
        check_eq("R4 refused keeps attn", f_at(0), 0);

        issue('h0F, 1);
        check_eq("R9 status cleared", int'(cmd_status), 0);
        check_eq("R5 removed state", f_st(0), 3);
        check_eq("R5 removed latch", int'(latch_open[0]), 1);
        check_eq("R5 removed presence", f_pr(0), 3);
        check_eq("R5 removed events", f_ev(0), 7);
        check_eq("R5 removal pulse", int'(removal[0]), 1);
        @(negedge clk);
        check_eq("R5 removal one cycle", int'(removal[0]), 0);

        issue('h03, 2);
        check_eq("R4 disable keeps pwr on", f_pw(1), 1);
        check_eq("R4 disabled", f_st(1), 3);
        check_eq("R5 no removal with pwr on", int'(latch_open[1]), 0);
        issue('h12, 2);
        check_eq("R4 disabled to enabled", f_st(1), 2);
        check_eq("R2 attention on", f_at(1), 1);

        issue('h40, 0);
        check_eq("R6 speed zero accepted", int'(cmd_status), 0);
        issue('h45, 0);
        check_eq("R6 speed five invalid mode", int'(cmd_status), 8);
        check_eq("R6 speed held", int'(bus_speed), 0);
        issue('h40, 0);
        check_eq("R9 mode bit cleared by next command", int'(cmd_status), 0);
        issue('h4A, 0);
        check_eq("R9 code 0x4A invalid", int'(cmd_status), 4);
        issue('hFF, 3);
        check_eq("R9 code 0xFF invalid", int'(cmd_status), 4);

        issue('h03, 2);
        issue('h0F, 4);
        check_eq("R5 slot3 removed", int'(removal[3]), 1);
        issue('h48, 0);
        check_eq("R8 power-all accepted", int'(cmd_status), 0);
        check_eq("R8 latch closed to power only", f_st(1), 1);
        check_eq("R8 latch closed pwr on", f_pw(1), 1);
        check_eq("R8 latch open pwr off", f_pw(2), 3);
        issue('h49, 0);
        check_eq("R8 power-only slot not forced to enabled", f_st(1), 1);
        issue('h03, 2);
        check_eq("R4 power only to disabled", f_st(1), 3);
        issue('h49, 0);
        check_eq("R8 enable-all from disabled", f_st(1), 2);
        check_eq("R8 open latch slot stays disabled", f_st(2), 3);

        evt_clr = 6'b000001;
        @(negedge clk);
        evt_clr = '0;
        check_eq("R11 cleared slot0 events", f_ev(0), 0);
        check_eq("R11 slot3 events kept", f_ev(3), 7);

        issue('h28, 3);
        check_eq("R2 pwr blink", f_pw(2), 2);
        check_eq("R2 attn blink", f_at(2), 2);
        check_eq("R4 keep state request", f_st(2), 3);

        cmd_ack = 1'b1;
        issue('h40, 0);
        cmd_ack = 1'b0;
        check_eq("R10 command beats ack", int'(cmd_detected), 1);

        // Pseudo-random stream, compared by the model each clock.
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            int sel;
            int c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = int'(lfsr[3:0]);
            if (sel < 9) c = int'(lfsr[9:4]) % 64;
            else if (sel < 11) c = 'h40 + int'(lfsr[6:4]);
            else if (sel < 13) c = 'h48;
            else if (sel < 15) c = 'h49;
            else c = 'h4A + int'(lfsr[8:4]);
            cmd_ack = lfsr[11];
            evt_clr = NS'(lfsr[15:10]) & {NS{lfsr[2]}};
            if (lfsr[14]) begin
                issue(c, int'(lfsr[12:10]));
            end else begin
                @(negedge clk);
            end
            cmd_ack = 1'b0;
            evt_clr = '0;
            if (n == 300) begin
                rst_n = 1'b0;
                slot_occ = 6'b110100;
                @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
            end
        end
        @(negedge clk);
        report();
    end

endmodule